// File: doc/BRIEF.md
# Signed Fixed-Point Requantizer with Clamping

This block narrows a signed two's-complement sample that carries a wide fraction field into a smaller signed word. The output word has one sign bit, T integer bits and F fraction bits. The fraction bits below the kept resolution are removed in one of three ways, chosen per sample by a 2-bit mode input: round to nearest, floor, or ceiling. The reduced value then passes through a clamp. The clamp replaces anything outside the output range with the nearest end of that range and raises a per-sample overflow or underflow flag.

The block is meant for fixed-point datapaths such as soft-value chains, where precision has to be cut between stages. The fraction reduction keeps one extra integer bit. This means the carry out of a rounding addition on a value close to the top of the range is caught and clamped instead of wrapping round to a small or negative value. An output register stage can be switched in by parameter, and it has a clock enable driven by the input valid. A sticky saturation indicator records that at least one clamp has happened since it was last cleared.

Top module: `rq_requant`

## Requirements
- R1: The output `out_data` is a signed two's-complement word of 1+T+F bits with an LSB weight of 2^-F. The input `in_data` is signed with IN_F fraction bits, and IN_F > F.
- R2: With mode 2'b00 (round), the result equals floor(x·2^F + 1/2): half an output LSB is added, then the tail is discarded. Exact ties therefore move toward positive infinity (for example, -0.5 LSB becomes 0 and -1.5 LSB becomes -1).
- R3: With mode 2'b01 (floor), the discarded tail is dropped with no increment. The result is floor(x·2^F). Mode 2'b11 behaves exactly like 2'b01.
- R4: With mode 2'b10 (ceiling), any nonzero discarded tail moves the result up by one output LSB. The result is ceil(x·2^F).
- R5: When the reduced value is at or above 2^T, `out_data` is the largest code, 2^(T+F)-1 in raw units, and `out_ovf` is 1. This includes the case where only the rounding or ceiling carry takes a value there.
- R6: When the reduced value is below -2^T, `out_data` is the most negative code, -2^(T+F) in raw units, and `out_unf` is 1.
- R7: A reduced value inside [-2^T, 2^T - 2^-F] appears unchanged on `out_data`, with both `out_ovf` and `out_unf` at 0.
- R8: With PIPE=1, `out_valid` equals `in_valid` from one cycle earlier, and the result for a sample appears one cycle after it is presented. While `in_valid` is 0, `out_data`, `out_ovf` and `out_unf` hold their values. With PIPE=0 the path has no register.
- R9: `sat_flag` goes to 1 on the clock edge that follows any cycle in which `out_valid` is 1 together with `out_ovf` or `out_unf`. It stays at 1 until a cycle with `sat_clr` high and no such event, after which it reads 0. An event in the same cycle as the clear wins over the clear.
- R10: While reset is active, `out_valid`, `out_data`, `out_ovf`, `out_unf` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample present on in_data |
| in_data | input | IN_W | Signed input sample, IN_F fraction bits |
| mode | input | 2 | Tail reduction: 00 round, 01 floor, 10 ceiling, 11 floor |
| sat_clr | input | 1 | Clears the sticky saturation indicator |
| out_valid | output | 1 | Result present on out_data |
| out_data | output | 1+T+F | Signed requantized result |
| out_ovf | output | 1 | Result was clamped to the top code |
| out_unf | output | 1 | Result was clamped to the bottom code |
| sat_flag | output | 1 | Sticky: a clamp has occurred since the last clear |

## Verification
The properties on valid latency and on output holding assume that `in_valid` is 0 while the port reset is active and through the two cycles in which the internal reset is still held after release. The bench keeps `in_valid` low until several cycles after `rst_n` rises. The clamp and sticky properties need no input constraints. Stimulus covers the whole input range with random codes in all four mode values. On top of that, directed codes land on exact ties, on values one raw step either side of both range limits, and on the extreme input codes, so the carry-into-clamp path is exercised in every mode.

// File: rtl/rq_pkg.sv
package rq_pkg;

  typedef enum logic [1:0] {
    RQ_ROUND = 2'b00,
    RQ_FLOOR = 2'b01,
    RQ_CEIL  = 2'b10,
    RQ_RSVD  = 2'b11
  } rq_mode_e;

endpackage

// File: rtl/rq_rst_sync.sv
module rq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/rq_tail_adj.sv
module rq_tail_adj
  import rq_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int DROP = 6,
  localparam int KW  = IN_W - DROP,
  localparam int SW  = KW + 1
) (
  input  logic [IN_W-1:0] din,
  input  rq_mode_e        mode,
  output logic [SW-1:0]   sum
);

  logic [KW-1:0]   kept;
  logic [DROP-1:0] tail;
  logic            inc;

  assign kept = din[IN_W-1:DROP];
  assign tail = din[DROP-1:0];

  // One shared incrementer serves round (half-LSB bit) and ceiling (any tail bit)
  always_comb begin
    unique case (mode)
      RQ_ROUND: inc = tail[DROP-1];
      RQ_CEIL:  inc = |tail;
      default:  inc = 1'b0;
    endcase
  end

  // Sign-extended by one bit so the increment carry is never lost
  assign sum = {kept[KW-1], kept} + {{KW{1'b0}}, inc};

endmodule

// File: rtl/rq_clamp.sv
module rq_clamp #(
  parameter int SW    = 11,
  parameter int OUT_W = 8,
  localparam int HW   = SW - OUT_W + 1
) (
  input  logic [SW-1:0]    val,
  output logic [OUT_W-1:0] dout,
  output logic             ovf,
  output logic             unf
);

  logic [HW-1:0]    head;
  logic             fits;
  logic [OUT_W-1:0] top_code;
  logic [OUT_W-1:0] bot_code;

  assign head     = val[SW-1:OUT_W-1];
  assign fits     = (head == {HW{1'b0}}) || (head == {HW{1'b1}});
  assign top_code = {1'b0, {(OUT_W-1){1'b1}}};
  assign bot_code = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    ovf  = 1'b0;
    unf  = 1'b0;
    dout = val[OUT_W-1:0];
    if (!fits) begin
      if (val[SW-1]) begin
        unf  = 1'b1;
        dout = bot_code;
      end else begin
        ovf  = 1'b1;
        dout = top_code;
      end
    end
  end

endmodule

// File: rtl/rq_stage.sv
module rq_stage #(
  parameter int W    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (PIPE) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (en) begin
          q_nxt = d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
        end else begin
          q_r <= q_nxt;
        end
      end

      assign q = q_r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/rq_requant.sv
module rq_requant
  import rq_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int IN_F = 10,
  parameter int T    = 3,
  parameter int F    = 4,
  parameter bit PIPE = 1'b1,
  localparam int OUT_W = 1 + T + F,
  localparam int DROP  = IN_F - F,
  localparam int SW    = IN_W - DROP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       mode,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf,
  output logic             out_unf,
  output logic             sat_flag
);

  logic             rst_n_i;
  logic [SW-1:0]    reduced;
  logic [OUT_W-1:0] clamped;
  logic             c_ovf;
  logic             c_unf;
  logic [OUT_W+1:0] bundle_d;
  logic [OUT_W+1:0] bundle_q;
  logic [0:0]       vld_q;
  logic             sat_evt;
  logic             sat_q;
  logic             sat_nxt;

  rq_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_i)
  );

  rq_tail_adj #(.IN_W(IN_W), .DROP(DROP)) u_adj (
    .din (in_data),
    .mode(rq_mode_e'(mode)),
    .sum (reduced)
  );

  rq_clamp #(.SW(SW), .OUT_W(OUT_W)) u_clamp (
    .val (reduced),
    .dout(clamped),
    .ovf (c_ovf),
    .unf (c_unf)
  );

  assign bundle_d = {c_ovf, c_unf, clamped};

  rq_stage #(.W(OUT_W + 2), .PIPE(PIPE)) u_data_stg (
    .clk  (clk),
    .rst_n(rst_n_i),
    .en   (in_valid),
    .d    (bundle_d),
    .q    (bundle_q)
  );

  rq_stage #(.W(1), .PIPE(PIPE)) u_vld_stg (
    .clk  (clk),
    .rst_n(rst_n_i),
    .en   (1'b1),
    .d    (in_valid),
    .q    (vld_q)
  );

  assign out_valid = vld_q[0];
  assign out_data  = bundle_q[OUT_W-1:0];
  assign out_unf   = bundle_q[OUT_W];
  assign out_ovf   = bundle_q[OUT_W+1];

  // Sticky indicator: a clamp event outranks a simultaneous clear
  assign sat_evt = out_valid && (out_ovf || out_unf);

  always_comb begin
    sat_nxt = sat_q;
    if (sat_evt) begin
      sat_nxt = 1'b1;
    end else if (sat_clr) begin
      sat_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sat_q <= 1'b0;
    end else begin
      sat_q <= sat_nxt;
    end
  end

  assign sat_flag = sat_q;

endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
  parameter int OUT_W = 8,
  parameter bit PIPE  = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             sat_clr,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_ovf,
  input logic             out_unf,
  input logic             sat_flag
);

  localparam logic [OUT_W-1:0] TOP_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] BOT_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  AST_OVF_TOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_data == TOP_CODE)); // R5

  AST_UNF_BOT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_data == BOT_CODE)); // R6

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovf && out_unf)); // R7

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_ovf || out_unf)) |=> sat_flag); // R9

  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !(out_valid && (out_ovf || out_unf))) |=> !sat_flag); // R9

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag); // R9

  generate
    if (PIPE) begin : g_pipe_chk
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R8

      AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_ovf) && $stable(out_unf))); // R8
    end
  endgenerate

endmodule

bind rq_requant rq_requant_chk #(.OUT_W(OUT_W), .PIPE(PIPE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .sat_clr  (sat_clr),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_ovf  (out_ovf),
  .out_unf  (out_unf),
  .sat_flag (sat_flag)
);

// File: tb/rq_requant_test.sv
`timescale 1ns/1ps
module rq_requant_test;

  localparam int IN_W  = 16;
  localparam int IN_F  = 10;
  localparam int T     = 3;
  localparam int F     = 4;
  localparam int OUT_W = 1 + T + F;
  localparam int DROP  = IN_F - F;
  localparam int QMAX  = (1 << (T + F)) - 1;
  localparam int QMIN  = -(1 << (T + F));
  localparam int LIM   = (1 << (T + F)) << DROP;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [IN_W-1:0]  in_data;
  logic [1:0]       mode;
  logic             sat_clr;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;
  logic             out_ovf;
  logic             out_unf;
  logic             sat_flag;

  int n_cmp;
  int n_bad;
  bit done;

  rq_requant #(.IN_W(IN_W), .IN_F(IN_F), .T(T), .F(F), .PIPE(1'b1)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .mode     (mode),
    .sat_clr  (sat_clr),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ovf  (out_ovf),
    .out_unf  (out_unf),
    .sat_flag (sat_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference: mathematical floor/round/ceil on the integer value, then clamp
  function automatic void ref_model(input int v, input int m,
                                    output int q, output bit o, output bit u);
    int r;
    int half;
    int full;
    half = 1 << (DROP - 1);
    full = (1 << DROP) - 1;
    if (m == 0)      r = (v + half) >>> DROP;
    else if (m == 2) r = (v + full) >>> DROP;
    else             r = v >>> DROP;
    o = 1'b0;
    u = 1'b0;
    q = r;
    if (r > QMAX) begin q = QMAX; o = 1'b1; end
    if (r < QMIN) begin q = QMIN; u = 1'b1; end
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; presents one sample and checks it one cycle later
  task automatic apply(input int v, input int m);
    int  q;
    bit  o;
    bit  u;
    int  act;
    string tag;
    in_valid = 1'b1;
    in_data  = v[IN_W-1:0];
    mode     = m[1:0];
    ref_model(v, m, q, o, u);
    @(posedge clk);
    @(negedge clk);
    if (o)           tag = "R5";
    else if (u)      tag = "R6";
    else if (m == 0) tag = "R2";
    else if (m == 2) tag = "R4";
    else             tag = "R3";
    act = int'($signed(out_data));
    check(tag, (act == q) && (out_ovf == o) && (out_unf == u) && out_valid,
          act * 8 + int'(out_ovf) * 4 + int'(out_unf) * 2 + int'(out_valid),
          q * 8 + int'(o) * 4 + int'(u) * 2 + 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int held;
    int dummy;
    n_cmp    = 0;
    n_bad    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    mode     = 2'b00;
    sat_clr  = 1'b0;
    dummy    = $urandom(32'd1357);
    repeat (3) @(negedge clk);

    // R10: reset state
    check("R10", (out_valid == 1'b0) && (out_data == '0) && !out_ovf && !out_unf && !sat_flag,
          int'(out_valid) + int'(out_data) + int'(out_ovf) + int'(out_unf) + int'(sat_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R7: in-range values pass unchanged in every mode
    for (int m = 0; m < 4; m++) begin
      apply(0, m);
      apply(5 << DROP, m);
      apply(-(7 << DROP), m);
    end

    // Directed corners across all four mode codes
    for (int m = 0; m < 4; m++) begin
      apply(-32, m);                      // negative tie, R2 toward +inf
      apply(-96, m);
      apply(32, m);                       // positive tie
      apply(LIM - 1, m);                  // just below top: carry into clamp, R5
      apply(LIM - (1 << (DROP - 1)), m);  // top tie
      apply(LIM - (1 << DROP), m);        // exact top code, R7
      apply(LIM, m);                      // first value past top, R5
      apply(-LIM, m);                     // exact bottom code, R7
      apply(-LIM - 1, m);                 // one step below bottom, R6 for floor
      apply(32767, m);                    // largest input, R5
      apply(-32768, m);                   // smallest input, R6
      apply(1, m);
      apply(-1, m);
    end

    // Random stimulus over the full range and near the limits
    for (int i = 0; i < 600; i++) begin
      int v;
      int m;
      v = int'($signed(16'($urandom)));
      m = int'($urandom_range(0, 3));
      if (i % 3 == 1) v = LIM - int'($urandom_range(0, 128));
      if (i % 3 == 2) v = -LIM + int'($urandom_range(0, 128)) - 64;
      apply(v, m);
    end

    // R8: data holds while in_valid is low, and out_valid follows one cycle late
    apply(3 << DROP, 1);
    held = int'($signed(out_data));
    in_valid = 1'b0;
    in_data  = 16'h7FFF;
    @(posedge clk);
    @(negedge clk);
    check("R8", (int'($signed(out_data)) == held) && !out_valid && !out_ovf,
          int'($signed(out_data)), held);

    // R9: sticky flag set, held, cleared, and set-wins-over-clear
    sat_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sat_clr = 1'b0;
    check("R9", sat_flag == 1'b0, int'(sat_flag), 0);
    apply(32767, 1);          // clamp visible now, flag rises on next edge
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9", sat_flag == 1'b1, int'(sat_flag), 1);
    apply(1 << DROP, 0);
    apply(2 << DROP, 0);
    check("R9", sat_flag == 1'b1, int'(sat_flag), 1);
    in_valid = 1'b0;
    sat_clr  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sat_clr = 1'b0;
    check("R9", sat_flag == 1'b0, int'(sat_flag), 0);
    apply(-32768, 1);         // underflow output present this cycle
    in_valid = 1'b0;
    sat_clr  = 1'b1;          // clear in the same cycle as the event
    @(posedge clk);
    @(negedge clk);
    sat_clr = 1'b0;
    check("R9", sat_flag == 1'b1, int'(sat_flag), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule